// File: doc/BRIEF.md
# Shared Two-Level Interrupt Aggregator

This block gathers the event pulses of a storage host controller into a local pending register. Software controls each bit through a local mask. Any unmasked pending bit forms one local request. That request is merged with the interrupt of a neighbouring controller in a small global register. The global register has one bit for each of the two controllers, and two global controls sit on top of it. The first, a status enable, decides whether a request may latch into the global register at all. The second, a signal enable, decides whether a latched global bit drives the single interrupt line.

All state is reached through a simple register bus with single-cycle write strobes and registered reads. Every status bit is cleared by writing a one to it. A source event that lands in the same cycle as the clearing write wins, so no event is ever lost. The interrupt line is a level output. It stays high until software clears the responsible global bit, and before that the local cause behind it.

Top module: `irqc_shared_top`

## Requirements
- R1: After a synchronous reset, every register reads zero and `irq_out` is low.
- R2: A one-cycle pulse on `src_evt[i]` sets local status bit i for the implemented positions 0, 1, 2, 3, 8, 9, 10 and 11, and the bit stays set until cleared. Positions 4 to 7 never set and read zero.
- R3: A write to the local status register (offset 0x004) clears exactly the bits written as 1 and leaves the others unchanged.
- R4: When a source pulse and a clearing write hit the same local bit in one cycle, the bit remains set.
- R5: The local enable register (0x008) stores only the implemented source positions. The global status-enable (0x804) and signal-enable (0x808) registers store bits 1:0 only. All other bits read zero.
- R6: Global status bit 0 (0x800) sets on the clock edge after a cycle in which some local status bit is pending and enabled while status-enable bit 0 is 1. It never sets while status-enable bit 0 is 0.
- R7: Global status bit 1 sets on the clock edge after a cycle in which `peer_irq` is high while status-enable bit 1 is 1. It never sets while status-enable bit 1 is 0.
- R8: Writing 1s to global status clears those bits, except where that bit's set condition holds in the same cycle, in which case it stays set.
- R9: `irq_out` is high exactly when some global status bit is set and its signal-enable bit is 1. Clearing signal enable masks the line but leaves global status unchanged.
- R10: Read data appears on `bus_rdata` with `bus_rvalid` high on the clock edge after `bus_rd`. An address outside the five mapped registers reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | SRC_W (12) | Single-cycle event pulses, one per local source position |
| peer_irq | input | 1 | Level interrupt request of the neighbouring controller |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (12) | Byte offset of the accessed register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| bus_rvalid | output | 1 | High for one cycle when `bus_rdata` carries a read result |
| irq_out | output | 1 | Level interrupt line |

## Verification
A source pulse reaches local status on the same edge that samples it. Global bit 0 follows one edge later, and `irq_out` rises together with that global bit because the line is a pure combination of registers. A register write takes effect on its edge, and a read returns the value held before the edge that samples it, one cycle after the strobe. The bench therefore inserts one idle cycle after a pulse before it reads global status. It samples `irq_out` on the falling edge after the write or set edge, and pushes each read's expected word into a queue that the monitor pops when `bus_rvalid` is seen.

// File: rtl/irqc_pkg.sv
// Package: shared constants and types of the two-level interrupt aggregator.
// Assumes byte offsets that fit in the address width chosen at the top.
package irqc_pkg;

    // Register offsets; software decodes these, so they are fixed.
    localparam int unsigned LOC_STAT_OFS = 'h004;
    localparam int unsigned LOC_MASK_OFS = 'h008;
    localparam int unsigned GLB_STAT_OFS = 'h800;
    localparam int unsigned GLB_SEN_OFS  = 'h804;
    localparam int unsigned GLB_SIG_OFS  = 'h808;

    // Slot order inside every global register.
    typedef enum int unsigned {
        GSLOT_OWN  = 0,
        GSLOT_PEER = 1
    } gslot_e;

    // Register selected by a bus address.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LSTAT,
        SEL_LMASK,
        SEL_GSTAT,
        SEL_GSEN,
        SEL_GSIG
    } reg_sel_e;

endpackage

// File: rtl/irqc_local_bank.sv
// Local bank: latches source pulses into a sticky status register that is
// cleared by writing ones, holds the enable mask and forms the local request.
// Assumes sources are one-cycle pulses; a set in the clearing cycle wins.
module irqc_local_bank #(
    parameter int unsigned SRC_W    = 12,
    parameter logic [SRC_W-1:0] IMPL_MASK = 12'hF0F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_evt,
    input  logic [SRC_W-1:0] stat_clr,
    input  logic             mask_we,
    input  logic [SRC_W-1:0] mask_wdata,
    output logic [SRC_W-1:0] stat_q,
    output logic [SRC_W-1:0] mask_q,
    output logic             pend
);

    // Sticky status: clear by write-one, new events override the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= ((stat_q & ~stat_clr) | src_evt) & IMPL_MASK;
        end
    end

    // Enable mask: only implemented positions are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= mask_wdata & IMPL_MASK;
        end
    end

    // Local request: any pending bit that is also enabled.
    always_comb begin
        pend = |(stat_q & mask_q);
    end

endmodule

// File: rtl/irqc_global_bank.sv
// Global bank: one sticky bit per controller slot, gated on entry by the
// status enable and on exit by the signal enable; drives the level line.
// Assumes set requests are levels sampled every cycle.
module irqc_global_bank #(
    parameter int unsigned NSLOT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] set_req,
    input  logic [NSLOT-1:0] stat_clr,
    input  logic             sen_we,
    input  logic             sig_we,
    input  logic [NSLOT-1:0] wdata,
    output logic [NSLOT-1:0] gstat_q,
    output logic [NSLOT-1:0] gsen_q,
    output logic [NSLOT-1:0] gsig_q,
    output logic             irq
);

    // Per-slot sticky status; the set condition wins over a clear.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gstat_q[s] <= 1'b0;
            end else begin
                gstat_q[s] <= (gstat_q[s] & ~stat_clr[s]) | (set_req[s] & gsen_q[s]);
            end
        end
    end

    // Status-enable and signal-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gsen_q <= '0;
            gsig_q <= '0;
        end else begin
            if (sen_we) gsen_q <= wdata;
            if (sig_we) gsig_q <= wdata;
        end
    end

    // Interrupt line: any latched slot whose signal enable is on.
    always_comb begin
        irq = |(gstat_q & gsig_q);
    end

endmodule

// File: rtl/irqc_regif.sv
// Register interface: decodes the bus address into write strobes and a
// registered read path with a one-cycle valid flag.
// Assumes at most one of write or read per cycle matters for a register.
module irqc_regif
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SRC_W  = 12,
    parameter int unsigned NSLOT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [SRC_W-1:0]  lstat,
    input  logic [SRC_W-1:0]  lmask,
    input  logic [NSLOT-1:0]  gstat,
    input  logic [NSLOT-1:0]  gsen,
    input  logic [NSLOT-1:0]  gsig,
    output logic [SRC_W-1:0]  lstat_clr,
    output logic              lmask_we,
    output logic [SRC_W-1:0]  lmask_wdata,
    output logic [NSLOT-1:0]  gstat_clr,
    output logic              gsen_we,
    output logic              gsig_we,
    output logic [NSLOT-1:0]  g_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid
);

    localparam int unsigned LPAD = DATA_W - SRC_W;
    localparam int unsigned GPAD = DATA_W - NSLOT;

    reg_sel_e          sel;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wdata_hi;

    // Address decode into a register select.
    always_comb begin
        if (bus_addr == ADDR_W'(LOC_STAT_OFS))      sel = SEL_LSTAT;
        else if (bus_addr == ADDR_W'(LOC_MASK_OFS)) sel = SEL_LMASK;
        else if (bus_addr == ADDR_W'(GLB_STAT_OFS)) sel = SEL_GSTAT;
        else if (bus_addr == ADDR_W'(GLB_SEN_OFS))  sel = SEL_GSEN;
        else if (bus_addr == ADDR_W'(GLB_SIG_OFS))  sel = SEL_GSIG;
        else                                        sel = SEL_NONE;
    end

    // Write strobes and clear masks for the banks.
    always_comb begin
        lmask_wdata = bus_wdata[SRC_W-1:0];
        g_wdata     = bus_wdata[NSLOT-1:0];
        lstat_clr   = (bus_wr && sel == SEL_LSTAT) ? bus_wdata[SRC_W-1:0] : '0;
        gstat_clr   = (bus_wr && sel == SEL_GSTAT) ? bus_wdata[NSLOT-1:0] : '0;
        lmask_we    = bus_wr && (sel == SEL_LMASK);
        gsen_we     = bus_wr && (sel == SEL_GSEN);
        gsig_we     = bus_wr && (sel == SEL_GSIG);
    end

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:SRC_W];

    // Read multiplexer, zero-extended; unmapped offsets give zero.
    always_comb begin
        case (sel)
            SEL_LSTAT: rd_mux = {{LPAD{1'b0}}, lstat};
            SEL_LMASK: rd_mux = {{LPAD{1'b0}}, lmask};
            SEL_GSTAT: rd_mux = {{GPAD{1'b0}}, gstat};
            SEL_GSEN:  rd_mux = {{GPAD{1'b0}}, gsen};
            SEL_GSIG:  rd_mux = {{GPAD{1'b0}}, gsig};
            default:   rd_mux = '0;
        endcase
    end

    // Registered read data and its one-cycle valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/irqc_shared_top.sv
// Top: two-level interrupt aggregator shared with a neighbouring controller.
// Local pending bits feed global slot 0, the peer request feeds slot 1.
// Assumes synchronous active-low reset and pulse-shaped local sources.
module irqc_shared_top
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SRC_W  = 12,
    parameter logic [SRC_W-1:0] IMPL_MASK = 12'hF0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src_evt,
    input  logic              peer_irq,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              irq_out
);

    localparam int unsigned NSLOT = 2;

    logic [SRC_W-1:0] lstat_q, lmask_q, lstat_clr, lmask_wdata;
    logic             lmask_we, local_pend;
    logic [NSLOT-1:0] gstat_q, gsen_q, gsig_q, gstat_clr, g_wdata, g_set;
    logic             gsen_we, gsig_we;

    // Slot order of the global register: own request, then the peer's.
    always_comb begin
        g_set              = '0;
        g_set[GSLOT_OWN]   = local_pend;
        g_set[GSLOT_PEER]  = peer_irq;
    end

    irqc_regif #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .NSLOT(NSLOT)
    ) u_regif (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .lstat(lstat_q), .lmask(lmask_q), .gstat(gstat_q), .gsen(gsen_q), .gsig(gsig_q),
        .lstat_clr(lstat_clr), .lmask_we(lmask_we), .lmask_wdata(lmask_wdata),
        .gstat_clr(gstat_clr), .gsen_we(gsen_we), .gsig_we(gsig_we), .g_wdata(g_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    irqc_local_bank #(
        .SRC_W(SRC_W), .IMPL_MASK(IMPL_MASK)
    ) u_local (
        .clk(clk), .rst_n(rst_n),
        .src_evt(src_evt), .stat_clr(lstat_clr),
        .mask_we(lmask_we), .mask_wdata(lmask_wdata),
        .stat_q(lstat_q), .mask_q(lmask_q), .pend(local_pend)
    );

    irqc_global_bank #(
        .NSLOT(NSLOT)
    ) u_global (
        .clk(clk), .rst_n(rst_n),
        .set_req(g_set), .stat_clr(gstat_clr),
        .sen_we(gsen_we), .sig_we(gsig_we), .wdata(g_wdata),
        .gstat_q(gstat_q), .gsen_q(gsen_q), .gsig_q(gsig_q), .irq(irq_out)
    );

endmodule

// File: rtl/irqc_sva.sv
// Checker: temporal properties of the aggregator, bound to the top module.
module irqc_sva #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned SRC_W  = 12,
    parameter logic [SRC_W-1:0] IMPL_MASK = 12'hF0F
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_W-1:0]  src_evt,
    input logic              peer_irq,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [SRC_W-1:0]  wr_lo,
    input logic [SRC_W-1:0]  lstat,
    input logic              pend,
    input logic [1:0]        gsen,
    input logic [1:0]        gstat,
    input logic [1:0]        gsig,
    input logic              irq_out
);

    // R2: an implemented source pulse is visible in local status next cycle.
    a_r2_pulse_latches: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_evt & IMPL_MASK) != '0) |=> ((lstat & $past(src_evt & IMPL_MASK)) == $past(src_evt & IMPL_MASK)));

    // R3: a clearing write with no new events leaves the written bits at zero.
    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h004) && src_evt == '0) |=> ((lstat & $past(wr_lo)) == '0));

    // R6: an enabled local request latches global slot 0.
    a_r6_own_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && gsen[0]) |=> gstat[0]);

    // R6: global slot 0 only rises after a qualified local request.
    a_r6_own_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gstat[0]) |-> $past(pend && gsen[0]));

    // R7: global slot 1 only rises after a qualified peer request.
    a_r7_peer_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gstat[1]) |-> $past(peer_irq && gsen[1]));

    // R9: with both signal enables off the line stays low.
    a_r9_line_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (gsig == 2'b00) |-> !irq_out);

endmodule

bind irqc_shared_top irqc_sva #(
    .ADDR_W(ADDR_W), .SRC_W(SRC_W), .IMPL_MASK(IMPL_MASK)
) u_irqc_sva (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .peer_irq(peer_irq),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .wr_lo(bus_wdata[SRC_W-1:0]),
    .lstat(lstat_q), .pend(local_pend), .gsen(gsen_q), .gstat(gstat_q),
    .gsig(gsig_q), .irq_out(irq_out)
);

// File: tb/test_irqc_shared_top.sv
// Scoreboard bench: driver tasks queue expected read words, a monitor pops
// and compares them when read data is flagged valid.
module test_irqc_shared_top;

    localparam int CLK_NS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] src_evt = '0;
    logic        peer_irq = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        irq_out;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_NS/2) clk = ~clk;

    irqc_shared_top i_irqc_shared_top (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .peer_irq(peer_irq),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_out(irq_out)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_exp(input logic [11:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [11:0] s);
        src_evt = s;
        tick();
        src_evt = '0;
    endtask

    task automatic pulse_and_clear(input logic [11:0] s, input logic [31:0] c);
        src_evt = s; bus_wr = 1'b1; bus_addr = 12'h004; bus_wdata = c;
        tick();
        src_evt = '0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        n_chk++;
        if (irq_out !== e) begin
            n_bad++;
            $display("FAIL %s irq_out actual=%0b expected=%0b", tag, irq_out, e);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Monitor: pop and compare one expected word per valid read.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R10 unexpected read actual=%08h expected=none", bus_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s rdata actual=%08h expected=%08h", t, bus_rdata, e);
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_NS * 50000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    // Driver: stimulus sequence by requirement.
    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        chk_irq(1'b0, "R1");
        rd_exp(12'h004, 32'h0, "R1");
        rd_exp(12'h008, 32'h0, "R1");
        rd_exp(12'h800, 32'h0, "R1");
        rd_exp(12'h804, 32'h0, "R1");
        rd_exp(12'h808, 32'h0, "R1");
        // R5: only implemented bits stored
        wr(12'h008, 32'hFFFF_FFFF);
        rd_exp(12'h008, 32'h0000_0F0F, "R5");
        wr(12'h804, 32'hFFFF_FFFF);
        rd_exp(12'h804, 32'h3, "R5");
        wr(12'h804, 32'h0);
        wr(12'h008, 32'h0);
        // R2: all source lines pulsed
        pulse(12'hFFF);
        rd_exp(12'h004, 32'h0000_0F0F, "R2");
        // R6: enabled request but status enable off -> no latch
        wr(12'h008, 32'h0000_0F0F);
        tick();
        rd_exp(12'h800, 32'h0, "R6");
        chk_irq(1'b0, "R6");
        // R3: partial clears
        wr(12'h004, 32'h0000_000F);
        rd_exp(12'h004, 32'h0000_0F00, "R3");
        wr(12'h004, 32'h0000_0F00);
        rd_exp(12'h004, 32'h0, "R3");
        // R6: latch of slot 0 with status enable on, line masked (R9)
        wr(12'h804, 32'h3);
        wr(12'h808, 32'h0);
        pulse(12'h200);
        tick();
        rd_exp(12'h800, 32'h1, "R6");
        chk_irq(1'b0, "R9");
        wr(12'h808, 32'h1);
        chk_irq(1'b1, "R9");
        wr(12'h808, 32'h0);
        chk_irq(1'b0, "R9");
        rd_exp(12'h800, 32'h1, "R9");
        wr(12'h808, 32'h1);
        // R8: clear while cause still pending -> stays set
        wr(12'h800, 32'h1);
        rd_exp(12'h800, 32'h1, "R8");
        wr(12'h004, 32'h0000_0200);
        wr(12'h800, 32'h1);
        rd_exp(12'h800, 32'h0, "R8");
        chk_irq(1'b0, "R8");
        // R4: event and clear on the same bit -> set wins
        pulse_and_clear(12'h400, 32'h0000_0400);
        rd_exp(12'h004, 32'h0000_0400, "R4");
        chk_irq(1'b1, "R4");
        pulse_and_clear(12'h800, 32'h0000_0400);
        rd_exp(12'h004, 32'h0000_0800, "R4");
        wr(12'h004, 32'h0000_0FFF);
        wr(12'h800, 32'h3);
        rd_exp(12'h800, 32'h0, "R8");
        // R7: peer request latches slot 1
        peer_irq = 1'b1;
        tick();
        rd_exp(12'h800, 32'h2, "R7");
        chk_irq(1'b0, "R9");
        wr(12'h808, 32'h2);
        chk_irq(1'b1, "R7");
        peer_irq = 1'b0;
        tick();
        wr(12'h800, 32'h2);
        rd_exp(12'h800, 32'h0, "R7");
        chk_irq(1'b0, "R7");
        wr(12'h804, 32'h1);
        peer_irq = 1'b1;
        repeat (2) tick();
        rd_exp(12'h800, 32'h0, "R7");
        peer_irq = 1'b0;
        // R2: unimplemented positions never set
        pulse(12'h0F0);
        rd_exp(12'h004, 32'h0, "R2");
        // R10: unmapped addresses read zero
        rd_exp(12'h00C, 32'h0, "R10");
        rd_exp(12'h100, 32'h0, "R10");
        repeat (3) tick();
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R10 pending reads actual=%0d expected=0", exp_q.size());
        end
        summary();
        $finish;
    end

endmodule